// File: doc/BRIEF.md
# CAN Arbitration and Control Field Serializer

This block takes one message buffer's four packed identifier registers and its length register, and turns them into the serial arbitration and control field bits of a CAN frame. The first bit out is the most significant identifier bit. The block reads the format bit from the packed registers and picks one of two sequences. The 29-bit extended sequence carries substitute-remote and format flags in the middle of the identifier. The 11-bit standard sequence places the remote flag directly after the identifier.

The surrounding bit engine pulses a load strobe to capture a buffer. It then pulses a shift enable once for each bit time and reads the serial output. When the last length-code bit has gone out, the block raises a done flag. The block does not perform stuffing, CRC, start-of-frame generation, timing or arbitration-loss handling.

Top module: `can_id_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle with `done_o`=0, `ext_o`=0 and `bit_o`=1.
- R2: An accepted load sets `ext_o` to bit 3 of `id_reg1_i` (1 = extended, 0 = standard). `ext_o` holds that value until the next accepted load.
- R3: Extended sequence, 38 bits: reg0[7:0], reg1[7:5], SRR, IDE(=1), reg1[2:0], reg2[7:0], reg3[7:1], RTR = reg3[0], two reserved 0 bits, DLC[3:0]. Each group is sent MSB first.
- R4: In extended format, SRR goes out as 1 whatever value is stored in reg1 bit 4.
- R5: Standard sequence, 18 bits: reg0[7:0], reg1[7:5], RTR = reg1[4], IDE = 0, one reserved 0 bit, DLC[3:0]. reg1[2:0], reg2 and reg3 are ignored.
- R6: The DLC is `dlen_i[3:0]`. Bits 7:4 of `dlen_i` have no effect on the output.
- R7: `bit_o` shows the current bit from the cycle after the load. It advances by exactly one bit for each cycle with `shift_en_i` high and holds while `shift_en_i` is low.
- R8: `done_o` rises in the cycle after the enable that consumes the last DLC bit, which is the 38th (extended) or 18th (standard) enable.
- R9: A load strobe while bits remain to be sent is ignored, including in the cycle of the final enable.
- R10: A load while idle or done is accepted and clears `done_o`. A shift enable in that same cycle is ignored.
- R11: `bit_o` is 1 (recessive) whenever no field is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Capture strobe for the buffer registers |
| id_reg0_i | input | 8 | Identifier register 0 |
| id_reg1_i | input | 8 | Identifier register 1 (format flag in bit 3) |
| id_reg2_i | input | 8 | Identifier register 2 |
| id_reg3_i | input | 8 | Identifier register 3 |
| dlen_i | input | 8 | Data length register; only bits 3:0 are used |
| shift_en_i | input | 1 | Advance one bit |
| bit_o | output | 1 | Serial field bit |
| done_o | output | 1 | Field fully sent |
| ext_o | output | 1 | Captured format, 1 = extended |

## Verification
A load strobe and a shift enable can fall in the same cycle. Which one acts depends on the state. While bits remain, the shift must advance and the load must be dropped. While idle or done, the load must win and the shift must not consume the first bit. The bench provokes both cases. It holds the load high for a whole field, including the cycle of the final enable, and it raises both strobes together in the done state. A behavioural bit-queue model judges each case on every clock, and the bench counts the enables each field takes to reach done.

// File: rtl/can_ser_pkg.sv
// Package: shared widths and field sizes for the identifier serializer.
// Assumes 8-bit buffer registers and a 4-bit data length code.
package can_ser_pkg;
    localparam int REG_W      = 8;
    localparam int DLC_W      = 4;
    localparam int EXT_ID_W   = 29;
    localparam int STD_ID_W   = 11;
    localparam int FMT_BIT    = 3;   // format flag position in register 1
    localparam int STD_RTR    = 4;   // remote flag position in register 1, standard layout
    // extended: id + SRR + IDE + RTR + 2 reserved + DLC
    localparam int EXT_LEN    = EXT_ID_W + 3 + 2 + DLC_W;
    // standard: id + RTR + IDE + 1 reserved + DLC
    localparam int STD_LEN    = STD_ID_W + 3 + DLC_W;
    localparam int FRAME_W    = EXT_LEN;
    localparam int CNT_W      = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_DONE  = 2'd2
    } ser_state_t;
endpackage

// File: rtl/can_field_assembler.sv
// Module: builds the left-aligned field bit vector and its length from the
// packed buffer registers. Purely combinational; assumes register layouts
// with the format flag in register 1 bit 3.
module can_field_assembler
    import can_ser_pkg::*;
(
    input  logic [REG_W-1:0]   reg0_i,
    input  logic [REG_W-1:0]   reg1_i,
    input  logic [REG_W-1:0]   reg2_i,
    input  logic [REG_W-1:0]   reg3_i,
    input  logic [REG_W-1:0]   dlen_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   len_o,
    output logic               ext_o
);
    localparam int STD_PAD = FRAME_W - STD_LEN;

    logic [EXT_ID_W-1:0] ext_id;
    logic [STD_ID_W-1:0] std_id;
    logic [DLC_W-1:0]    dlc;

    // Gather identifier bits from the register fields for each layout.
    always_comb begin
        ext_id = {reg0_i, reg1_i[7:5], reg1_i[2:0], reg2_i, reg3_i[7:1]};
        std_id = {reg0_i, reg1_i[7:5]};
        dlc    = dlen_i[DLC_W-1:0];
        ext_o  = reg1_i[FMT_BIT];
    end

    // Pick the sequence for the detected format, MSB at the top of the vector.
    always_comb begin
        if (ext_o) begin
            frame_o = {ext_id[EXT_ID_W-1:18], 1'b1, 1'b1, ext_id[17:0],
                       reg3_i[0], 2'b00, dlc};
            len_o   = CNT_W'(EXT_LEN);
        end else begin
            frame_o = {std_id, reg1_i[STD_RTR], 1'b0, 1'b0, dlc,
                       {STD_PAD{1'b0}}};
            len_o   = CNT_W'(STD_LEN);
        end
    end
endmodule

// File: rtl/can_bit_shifter.sv
// Module: holds the captured field and shifts it out one bit per enable.
// Assumes len_i is nonzero and not above FRAME_W. Loads are taken only
// while no field is in flight.
module can_bit_shifter
    import can_ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               shift_en_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CNT_W-1:0]   len_i,
    input  logic               ext_i,
    output logic               bit_o,
    output logic               done_o,
    output logic               ext_o
);
    ser_state_t         state;
    logic [FRAME_W-1:0] sreg;
    logic [CNT_W-1:0]   remain;
    logic               fmt_q;

    // Sequencer: capture on load when free, shift on enable while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SER_IDLE;
            sreg   <= '0;
            remain <= '0;
            fmt_q  <= 1'b0;
        end else if (state == SER_SHIFT) begin
            if (shift_en_i) begin
                sreg   <= sreg << 1;
                remain <= remain - 1'b1;
                if (remain == CNT_W'(1)) state <= SER_DONE;
            end
        end else if (load_i) begin
            sreg   <= frame_i;
            remain <= len_i;
            fmt_q  <= ext_i;
            state  <= SER_SHIFT;
        end
    end

    // Output decode: head bit while busy, recessive otherwise.
    always_comb begin
        bit_o  = (state == SER_SHIFT) ? sreg[FRAME_W-1] : 1'b1;
        done_o = (state == SER_DONE);
        ext_o  = fmt_q;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!done_o && !ext_o && bit_o));
    assert_fmt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_SHIFT) |=> $stable(ext_o));
    assert_hold_no_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_SHIFT && !shift_en_i) |=> $stable(bit_o) && $stable(remain));
    assert_done_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_SHIFT && shift_en_i && remain == CNT_W'(1)) |=> done_o);
    assert_busy_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_SHIFT) |-> (remain != '0));
    assert_load_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_SHIFT && load_i && !shift_en_i) |=> $stable(sreg));
    assert_load_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SER_SHIFT && load_i) |=> (!done_o && remain == $past(len_i)));
    assert_idle_recessive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SER_SHIFT) |-> bit_o);
endmodule

// File: rtl/can_id_serializer.sv
// Module: top of the arbitration/control field serializer. Decodes the
// buffer registers and streams the selected sequence MSB first.
// Assumes the caller pulses shift_en_i once per bit time.
module can_id_serializer
    import can_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [REG_W-1:0] id_reg0_i,
    input  logic [REG_W-1:0] id_reg1_i,
    input  logic [REG_W-1:0] id_reg2_i,
    input  logic [REG_W-1:0] id_reg3_i,
    input  logic [REG_W-1:0] dlen_i,
    input  logic             shift_en_i,
    output logic             bit_o,
    output logic             done_o,
    output logic             ext_o
);
    logic [FRAME_W-1:0] asm_frame;
    logic [CNT_W-1:0]   asm_len;
    logic               asm_ext;

    can_field_assembler u_asm (
        .reg0_i  (id_reg0_i),
        .reg1_i  (id_reg1_i),
        .reg2_i  (id_reg2_i),
        .reg3_i  (id_reg3_i),
        .dlen_i  (dlen_i),
        .frame_o (asm_frame),
        .len_o   (asm_len),
        .ext_o   (asm_ext)
    );

    can_bit_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .shift_en_i (shift_en_i),
        .frame_i    (asm_frame),
        .len_i      (asm_len),
        .ext_i      (asm_ext),
        .bit_o      (bit_o),
        .done_o     (done_o),
        .ext_o      (ext_o)
    );

    // Length always fits the shift register (R3 / R5 sizing).
    assert_len_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (asm_len == CNT_W'(EXT_LEN) || asm_len == CNT_W'(STD_LEN)));
endmodule

// File: tb/can_id_serializer_tb.sv
module can_id_serializer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic       shift_en_i = 1'b0;
    logic [7:0] r0 = '0, r1 = '0, r2 = '0, r3 = '0, dl = '0;
    logic       bit_o, done_o, ext_o;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";

    // behavioural reference state
    bit m_busy = 0, m_done = 0, m_ext = 0;
    bit q[$];

    always #10 clk = ~clk;

    can_id_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i),
        .id_reg0_i(r0), .id_reg1_i(r1), .id_reg2_i(r2), .id_reg3_i(r3),
        .dlen_i(dl), .shift_en_i(shift_en_i),
        .bit_o(bit_o), .done_o(done_o), .ext_o(ext_o)
    );

    task automatic check(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_int(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected bit list per R3/R4/R5/R6.
    function automatic void build(logic [7:0] a, logic [7:0] b, logic [7:0] c,
                                  logic [7:0] d, logic [7:0] l);
        q.delete();
        if (b[3]) begin
            for (int i = 7; i >= 0; i--) q.push_back(a[i]);
            for (int i = 7; i >= 5; i--) q.push_back(b[i]);
            q.push_back(1'b1);           // SRR forced (R4)
            q.push_back(1'b1);           // IDE
            for (int i = 2; i >= 0; i--) q.push_back(b[i]);
            for (int i = 7; i >= 0; i--) q.push_back(c[i]);
            for (int i = 7; i >= 1; i--) q.push_back(d[i]);
            q.push_back(d[0]);           // RTR
            q.push_back(1'b0);
            q.push_back(1'b0);
        end else begin
            for (int i = 7; i >= 0; i--) q.push_back(a[i]);
            for (int i = 7; i >= 5; i--) q.push_back(b[i]);
            q.push_back(b[4]);           // RTR
            q.push_back(1'b0);           // IDE
            q.push_back(1'b0);           // reserved
        end
        for (int i = 3; i >= 0; i--) q.push_back(l[i]);   // DLC only (R6)
    endfunction

    // Reference update on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_ext = 0; q.delete();
        end else if (m_busy) begin
            if (shift_en_i) begin
                void'(q.pop_front());
                if (q.size() == 0) begin m_busy = 0; m_done = 1; end
            end
        end else if (load_i) begin
            build(r0, r1, r2, r3, dl);
            m_ext = r1[3]; m_busy = 1; m_done = 0;
        end
    end

    // Compare against the reference every cycle, away from the active edge.
    always @(negedge clk) begin
        check(cur_req, "bit_o", bit_o, m_busy ? q[0] : 1'b1);
        check(cur_req, "done_o", done_o, m_done);
        check(cur_req, "ext_o", ext_o, m_ext);
    end

    // Load a buffer and shift until done. gap: enable every other cycle.
    // hold: keep load high throughout (R9). both: shift with the load (R10).
    task automatic run_frame(string req, logic [7:0] a, logic [7:0] b, logic [7:0] c,
                             logic [7:0] d, logic [7:0] l, bit gap, bit hold,
                             bit both, int exp_len);
        int n = 0;
        int cyc = 0;
        cur_req = req;
        @(negedge clk);
        r0 = a; r1 = b; r2 = c; r3 = d; dl = l;
        load_i = 1'b1; shift_en_i = both;
        @(negedge clk);
        load_i = hold;
        if (hold) begin r0 = ~a; r1 = b ^ 8'h08; r2 = ~c; r3 = ~d; dl = ~l; end
        while (!done_o && cyc < 200) begin
            shift_en_i = gap ? cyc[0] : 1'b1;
            if (shift_en_i) n++;
            cyc++;
            @(negedge clk);
        end
        shift_en_i = 1'b0; load_i = 1'b0;
        check_int(req, "enables to done (R8)", n, exp_len);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: enables with nothing loaded leave the line recessive.
        cur_req = "R11";
        shift_en_i = 1'b1;
        repeat (4) @(negedge clk);
        shift_en_i = 1'b0;
        // R3/R4/R6/R2: extended, SRR stored 0, high length bits set.
        run_frame("R3", 8'hA5, 8'hCB, 8'h3C, 8'h97, 8'hF5, 0, 0, 0, 38);
        run_frame("R4", 8'h00, 8'h08, 8'h00, 8'h00, 8'hF0, 0, 0, 0, 38);
        // R5/R7: standard with gaps in the enable.
        run_frame("R5", 8'h5A, 8'hB7, 8'hFF, 8'hFF, 8'h08, 1, 0, 0, 18);
        run_frame("R7", 8'hC3, 8'h45, 8'h00, 8'h01, 8'hA7, 1, 0, 0, 18);
        // R9: load held high for a whole field, final enable included.
        run_frame("R9", 8'h12, 8'h3A, 8'h56, 8'h78, 8'h09, 0, 1, 0, 38);
        run_frame("R9", 8'hF0, 8'h10, 8'h00, 8'h00, 8'h03, 1, 1, 0, 18);
        // R10: load and enable together in the done state.
        run_frame("R10", 8'h81, 8'hEF, 8'h42, 8'h24, 8'h0E, 0, 0, 1, 38);
        run_frame("R2", 8'h7E, 8'hE0, 8'h99, 8'h66, 8'h01, 0, 0, 1, 18);
        // R6/R8: assorted buffers from a fixed generator.
        begin
            logic [31:0] s = 32'h1234_5678;
            for (int k = 0; k < 8; k++) begin
                logic [7:0] v [5];
                for (int j = 0; j < 5; j++) begin
                    s = s * 32'd1664525 + 32'd1013904223;
                    v[j] = s[31:24];
                end
                run_frame(k[0] ? "R6" : "R8", v[0], v[1], v[2], v[3], v[4],
                          k[1], k[2], k[0], v[1][3] ? 38 : 18);
            end
        end
        // R1: reset mid-field returns to idle.
        cur_req = "R1";
        @(negedge clk);
        r1 = 8'h08; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0; shift_en_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0; shift_en_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule